// File: doc/BRIEF.md
# Clock Relock Sequencing Controller

This block governs how new clock-generation settings reach the running clock tree. Software writes settings into a bank of staging (front) registers over a simple write port. Those writes leave the clocks alone. The values move into the active bank only when software sets both relock command bits, one for the PLL and one for the divider. The move also requires that every staging register has been written since the previous transfer. If any staging register was skipped, the block raises an error flag and changes nothing.

During a relock, every clock-enable output drops. It stays low until a modelled lock interval has elapsed. That interval is a minimum count of reference-clock cycles, combined with an external lock input that may be tied high. A hard or soft reset request seen during the relock is held on the matching reset output. The output stays asserted for a programmable number of reference cycles after the clocks resume.

The relock bits never clear themselves. A new relock cannot start until software has written both bits back to zero. Power-on reset is the synchronous reset of the block. It aborts any relock at once and reloads the active settings from the low portion of the reset configuration word.

Top module: `clk_relock_ctrl`

## Requirements
- R1: While `por` is high, the active settings load from `boot_cfg`, the staging registers load from `boot_cfg`, and the control register clears. After `por` falls, `clk_en` is all ones, and `relock_busy`, `relock_done` and `relock_err` are 0.
- R2: Writes to staging addresses 0 to NUM_FRONT-1 do not change `active_cfg`. Staging register i occupies bits [i*REG_W +: REG_W] of `active_cfg` once it is transferred.
- R3: The control register sits at address NUM_FRONT. Bit 0 is the PLL relock bit, bit 1 is the divider relock bit, and bits [7:2] hold the stretch count. If both relock bits are seen set while idle and all staging registers have been written, the staging values appear on `active_cfg` one cycle after the control write takes effect, and the written-tracking clears.
- R4: With only one of the two relock bits set, no relock starts and `active_cfg` is unchanged.
- R5: A relock request made while any staging register is unwritten sets `relock_err`. It performs no transfer and keeps the clocks running. The next successful relock clears `relock_err`.
- R6: `clk_en` is all zeros for exactly LOCK_CYCLES cycles when `lock_in` is high. If `lock_in` is still low after that, `clk_en` stays zero until `lock_in` rises.
- R7: `relock_busy` is 1 from the trigger until lock is reached. `relock_done` then reads 1 until the next trigger or `por`. The two are never 1 together.
- R8: After a relock completes, no further relock starts while either relock bit remains set, even if all staging registers are written again.
- R9: A staging write during a relock updates only the staging register, and `active_cfg` holds.
- R10: A `hard_req` or `soft_req` seen during a relock keeps the matching reset output asserted through the relock. After `clk_en` returns, the output stays asserted for the programmed stretch count of cycles.
- R11: Outside a relock, a reset request passes straight to its output with no stretch.
- R12: `por` during a relock ends it at once: `clk_en` returns to all ones and `active_cfg` returns to `boot_cfg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| boot_cfg | input | NUM_FRONT*REG_W | Low portion of the reset configuration word |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (staging registers, then control) |
| wr_data | input | REG_W | Write data |
| lock_in | input | 1 | Lock indication; tie high to use the cycle counter alone |
| hard_req | input | 1 | Hard reset request |
| soft_req | input | 1 | Soft reset request |
| clk_en | output | NUM_CLK | Clock enables for the system clocks |
| hard_rst | output | 1 | Stretched hard reset |
| soft_rst | output | 1 | Stretched soft reset |
| active_cfg | output | NUM_FRONT*REG_W | Active clock settings |
| relock_busy | output | 1 | Relock in progress |
| relock_done | output | 1 | Last relock reached lock |
| relock_err | output | 1 | Relock requested with a staging register unwritten |

## Verification
The bench counts the exact number of cycles the enables stay low. A design off by one on the lock counter, or one that frees the clocks early while `lock_in` is low, fails there. It writes a staging register in the middle of a relock and then reloads all of them while the command bits are still set. Those steps catch an active bank that follows writes, and a sequencer that starts again from bits left standing. It drops a hard reset request before lock and counts the stretch cycles after the clocks return, so a stretcher that forgets the request or miscounts the stretch is seen. Power-on reset is pulsed in the middle of a lock, and a relock is attempted with one register unwritten; these expose a sequencer that ignores the abort or transfers partial settings.

// File: rtl/clk_relock_pkg.sv
package clk_relock_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOCK = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

    // control register layout: two command bits, then the stretch count
    localparam int CMD_PLL_BIT = 0;
    localparam int CMD_DIV_BIT = 1;
    localparam int STRETCH_LSB = 2;

    typedef struct packed {
        logic div_bit;
        logic pll_bit;
    } relock_cmd_t;

    function automatic logic cmd_full(relock_cmd_t c);
        return c.pll_bit & c.div_bit;
    endfunction

    function automatic logic cmd_clear(relock_cmd_t c);
        return ~(c.pll_bit | c.div_bit);
    endfunction

endpackage

// File: rtl/relock_regbank.sv
module relock_regbank #(
    parameter int NUM_FRONT = 3,
    parameter int REG_W     = 16,
    parameter int ADDR_W    = 2,
    parameter int CTRL_W    = 8
) (
    input  logic                       clk,
    input  logic                       por,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [NUM_FRONT*REG_W-1:0] boot_cfg,
    input  logic                       load_active,
    output logic [NUM_FRONT*REG_W-1:0] active_flat,
    output logic                       all_written,
    output logic [CTRL_W-1:0]          ctrl_q
);
    logic [NUM_FRONT-1:0] written_q;

    for (genvar i = 0; i < NUM_FRONT; i++) begin : g_slot
        logic [REG_W-1:0] front_q;
        logic [REG_W-1:0] act_q;
        logic             hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (por) begin
                front_q      <= boot_cfg[i*REG_W +: REG_W];
                act_q        <= boot_cfg[i*REG_W +: REG_W];
                written_q[i] <= 1'b0;
            end else begin
                if (load_active) begin
                    act_q        <= front_q;
                    written_q[i] <= 1'b0;
                end
                if (hit) begin
                    front_q      <= wr_data;
                    written_q[i] <= 1'b1;
                end
            end
        end

        assign active_flat[i*REG_W +: REG_W] = act_q;
    end

    always_ff @(posedge clk) begin
        if (por)
            ctrl_q <= '0;
        else if (wr_en && (wr_addr == ADDR_W'(NUM_FRONT)))
            ctrl_q <= wr_data[CTRL_W-1:0];
    end

    assign all_written = &written_q;
endmodule

// File: rtl/relock_seq.sv
module relock_seq
    import clk_relock_pkg::*;
#(
    parameter int LOCK_CYCLES = 20
) (
    input  logic        clk,
    input  logic        por,
    input  relock_cmd_t cmd,
    input  logic        all_written,
    input  logic        lock_in,
    output logic        load_active,
    output logic        lock_end,
    output logic        busy,
    output logic        done,
    output logic        seq_err
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             trigger;

    assign trigger     = (state_q == SEQ_IDLE) && cmd_full(cmd);
    assign load_active = trigger && all_written;
    assign lock_end    = (state_q == SEQ_LOCK) && (cnt_q == CNT_LAST) && lock_in;
    assign busy        = (state_q == SEQ_LOCK);

    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: if (trigger) state_d = all_written ? SEQ_LOCK : SEQ_HOLD;
            SEQ_LOCK: if (lock_end) state_d = SEQ_HOLD;
            SEQ_HOLD: if (cmd_clear(cmd)) state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
            seq_err <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_active)
                cnt_q <= '0;
            else if (busy && cnt_q != CNT_LAST)
                cnt_q <= cnt_q + 1'b1;
            if (load_active)
                done <= 1'b0;
            else if (lock_end)
                done <= 1'b1;
            if (load_active)
                seq_err <= 1'b0;
            else if (trigger)
                seq_err <= 1'b1;
        end
    end
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int STR_W = 6
) (
    input  logic             clk,
    input  logic             por,
    input  logic             in_lock,
    input  logic             lock_end,
    input  logic [STR_W-1:0] stretch_len,
    input  logic             req,
    output logic             rst_out
);
    logic             pend_q;
    logic [STR_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (por) begin
            pend_q <= 1'b0;
            left_q <= '0;
        end else if (lock_end) begin
            pend_q <= 1'b0;
            left_q <= (pend_q || req) ? stretch_len : '0;
        end else begin
            if (in_lock && req)
                pend_q <= 1'b1;
            if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    assign rst_out = req || pend_q || (left_q != '0);
endmodule

// File: rtl/clk_relock_ctrl.sv
module clk_relock_ctrl
    import clk_relock_pkg::*;
#(
    parameter int NUM_FRONT   = 3,
    parameter int REG_W       = 16,
    parameter int NUM_CLK     = 4,
    parameter int LOCK_CYCLES = 20,
    parameter int STR_W       = 6,
    parameter int ADDR_W      = $clog2(NUM_FRONT + 1)
) (
    input  logic                       clk,
    input  logic                       por,
    input  logic [NUM_FRONT*REG_W-1:0] boot_cfg,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic                       lock_in,
    input  logic                       hard_req,
    input  logic                       soft_req,
    output logic [NUM_CLK-1:0]         clk_en,
    output logic                       hard_rst,
    output logic                       soft_rst,
    output logic [NUM_FRONT*REG_W-1:0] active_cfg,
    output logic                       relock_busy,
    output logic                       relock_done,
    output logic                       relock_err
);
    localparam int CTRL_W = STRETCH_LSB + STR_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic              all_written;
    logic              load_active;
    logic              lock_end;
    relock_cmd_t       cmd;
    logic [1:0]        rst_req_v;
    logic [1:0]        rst_out_v;

    assign cmd.pll_bit = ctrl_q[CMD_PLL_BIT];
    assign cmd.div_bit = ctrl_q[CMD_DIV_BIT];

    relock_regbank #(
        .NUM_FRONT(NUM_FRONT), .REG_W(REG_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)
    ) u_bank (
        .clk(clk), .por(por), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .boot_cfg(boot_cfg), .load_active(load_active), .active_flat(active_cfg),
        .all_written(all_written), .ctrl_q(ctrl_q)
    );

    relock_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_seq (
        .clk(clk), .por(por), .cmd(cmd), .all_written(all_written), .lock_in(lock_in),
        .load_active(load_active), .lock_end(lock_end), .busy(relock_busy),
        .done(relock_done), .seq_err(relock_err)
    );

    assign rst_req_v = {soft_req, hard_req};

    for (genvar g = 0; g < 2; g++) begin : g_rst
        rst_stretch #(.STR_W(STR_W)) u_str (
            .clk(clk), .por(por), .in_lock(relock_busy), .lock_end(lock_end),
            .stretch_len(ctrl_q[STRETCH_LSB +: STR_W]), .req(rst_req_v[g]),
            .rst_out(rst_out_v[g])
        );
    end

    assign hard_rst = rst_out_v[0];
    assign soft_rst = rst_out_v[1];
    assign clk_en   = {NUM_CLK{~relock_busy}};
endmodule

// File: rtl/clk_relock_ctrl_chk.sv
module clk_relock_ctrl_chk #(
    parameter int NUM_FRONT   = 3,
    parameter int REG_W       = 16,
    parameter int NUM_CLK     = 4,
    parameter int LOCK_CYCLES = 20
) (
    input logic                       clk,
    input logic                       por,
    input logic [NUM_FRONT*REG_W-1:0] boot_cfg,
    input logic                       hard_req,
    input logic [NUM_CLK-1:0]         clk_en,
    input logic                       hard_rst,
    input logic [NUM_FRONT*REG_W-1:0] active_cfg,
    input logic                       relock_busy,
    input logic                       relock_done,
    input logic                       relock_err
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (por)
            run_q <= 0;
        else if (relock_busy && run_q < LOCK_CYCLES)
            run_q <= run_q + 1;
        else if (!relock_busy)
            run_q <= 0;
    end

    AST_CLK_OFF_WHEN_BUSY: assert property (@(posedge clk) disable iff (por)
        relock_busy |-> (clk_en == '0)); // R6

    AST_LOCK_MIN_LEN: assert property (@(posedge clk) disable iff (por)
        (relock_busy && run_q < LOCK_CYCLES - 1) |=> relock_busy); // R6

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (por)
        !(relock_busy && relock_done)); // R7

    AST_ACTIVE_HOLD_IN_LOCK: assert property (@(posedge clk) disable iff (por)
        (relock_busy && $past(relock_busy)) |-> $stable(active_cfg)); // R9

    AST_ERR_KEEPS_CLOCKS: assert property (@(posedge clk) disable iff (por)
        relock_err |-> (!relock_busy && clk_en == '1)); // R5

    AST_RST_HELD_IN_LOCK: assert property (@(posedge clk) disable iff (por)
        (relock_busy && $past(relock_busy) && $past(hard_req)) |-> hard_rst); // R10

    AST_POR_ABORTS: assert property (@(posedge clk) disable iff (por)
        $past(por) |-> (!relock_busy && clk_en == '1 && active_cfg == boot_cfg)); // R12
endmodule

bind clk_relock_ctrl clk_relock_ctrl_chk #(
    .NUM_FRONT(NUM_FRONT), .REG_W(REG_W), .NUM_CLK(NUM_CLK), .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
    .clk(clk), .por(por), .boot_cfg(boot_cfg), .hard_req(hard_req), .clk_en(clk_en),
    .hard_rst(hard_rst), .active_cfg(active_cfg), .relock_busy(relock_busy),
    .relock_done(relock_done), .relock_err(relock_err)
);

// File: tb/test_clk_relock_ctrl.sv
module test_clk_relock_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NF   = 3;
    localparam int RW   = 16;
    localparam int NC   = 4;
    localparam int LOCK = 20;
    localparam int AW   = 2;
    localparam logic [AW-1:0] CTRL_A = AW'(NF);
    localparam logic [47:0] BOOT = 48'h3333_2222_1111;

    typedef struct {
        string       tag;
        int          sel;
        logic [63:0] exp;
    } sb_item_t;

    logic clk = 0;
    logic por = 1;
    logic [NF*RW-1:0] boot_cfg = BOOT;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic lock_in = 1;
    logic hard_req = 0;
    logic soft_req = 0;
    logic [NC-1:0] clk_en;
    logic hard_rst, soft_rst, relock_busy, relock_done, relock_err;
    logic [NF*RW-1:0] active_cfg;

    sb_item_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    clk_relock_ctrl i_clk_relock_ctrl (
        .clk(clk), .por(por), .boot_cfg(boot_cfg), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock_in(lock_in), .hard_req(hard_req), .soft_req(soft_req),
        .clk_en(clk_en), .hard_rst(hard_rst), .soft_rst(soft_rst), .active_cfg(active_cfg),
        .relock_busy(relock_busy), .relock_done(relock_done), .relock_err(relock_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] observe(int sel);
        case (sel)
            0: return 64'(active_cfg);
            1: return 64'(clk_en);
            2: return 64'(relock_busy);
            3: return 64'(relock_done);
            4: return 64'(relock_err);
            5: return 64'(hard_rst);
            default: return 64'(soft_rst);
        endcase
    endfunction

    // monitor: compares queued expectations just after each falling edge
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [63:0] act;
            it = sb_q.pop_front();
            act = observe(it.sel);
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_out(string tag, int sel, logic [63:0] exp);
        sb_q.push_back('{tag, sel, exp});
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [RW-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(2);
        por = 0;
        // R1 reset state
        expect_out("R1", 0, 64'(BOOT));
        expect_out("R1", 1, 64'hF);
        expect_out("R1", 2, 0);
        expect_out("R1", 3, 0);
        expect_out("R1", 4, 0);
        cyc(1);

        // R2 staging writes leave active alone
        wr(0, 16'hA0A0); wr(1, 16'hA1A1); wr(2, 16'hA2A2);
        expect_out("R2", 0, 64'(BOOT));
        expect_out("R2", 1, 64'hF);

        // R4 single command bit does nothing
        wr(CTRL_A, 16'h0001);
        cyc(2);
        expect_out("R4", 2, 0);
        expect_out("R4", 0, 64'(BOOT));
        wr(CTRL_A, 16'h0000);

        // R11 pass-through outside relock
        soft_req = 1;
        expect_out("R11", 6, 1);
        cyc(1);
        soft_req = 0;
        expect_out("R11", 6, 0);

        // R3 relock, stretch count 5
        wr(CTRL_A, 16'h0017);
        cyc(1);
        expect_out("R3", 0, 64'(48'hA2A2_A1A1_A0A0));
        expect_out("R7", 2, 1);
        expect_out("R6", 1, 0);
        hard_req = 1;
        expect_out("R10", 5, 1);
        wr(0, 16'hB0B0);
        hard_req = 0;
        expect_out("R9", 0, 64'(48'hA2A2_A1A1_A0A0));
        expect_out("R10", 5, 1);
        cyc(LOCK - 3);
        expect_out("R6", 2, 1);
        cyc(1);
        expect_out("R6", 1, 0);
        cyc(1);
        expect_out("R6", 1, 64'hF);
        expect_out("R7", 2, 0);
        expect_out("R7", 3, 1);
        expect_out("R10", 5, 1);
        cyc(4);
        expect_out("R10", 5, 1);
        cyc(1);
        expect_out("R10", 5, 0);

        // R8 bits still set: reloading staging must not retrigger
        wr(0, 16'hC0C0); wr(1, 16'hC1C1); wr(2, 16'hC2C2);
        cyc(2);
        expect_out("R8", 2, 0);
        expect_out("R8", 0, 64'(48'hA2A2_A1A1_A0A0));
        expect_out("R8", 3, 1);
        wr(CTRL_A, 16'h0000);
        wr(CTRL_A, 16'h0003);
        cyc(1);
        expect_out("R3", 2, 1);
        expect_out("R3", 0, 64'(48'hC2C2_C1C1_C0C0));

        // R12 power-on reset aborts relock
        cyc(3);
        por = 1;
        cyc(1);
        por = 0;
        expect_out("R12", 1, 64'hF);
        expect_out("R12", 2, 0);
        expect_out("R12", 0, 64'(BOOT));
        expect_out("R12", 3, 0);

        // R5 missing staging register
        wr(0, 16'hD0D0); wr(1, 16'hD1D1);
        wr(CTRL_A, 16'h0003);
        cyc(1);
        expect_out("R5", 4, 1);
        expect_out("R5", 2, 0);
        expect_out("R5", 1, 64'hF);
        expect_out("R5", 0, 64'(BOOT));
        wr(CTRL_A, 16'h0000);
        wr(2, 16'hD2D2);
        lock_in = 0;
        wr(CTRL_A, 16'h0003);
        cyc(1);
        expect_out("R5", 4, 0);
        expect_out("R3", 0, 64'(48'hD2D2_D1D1_D0D0));

        // R6 lock input low extends the gating
        cyc(LOCK + 5);
        expect_out("R6", 2, 1);
        expect_out("R6", 1, 0);
        lock_in = 1;
        cyc(1);
        expect_out("R6", 1, 64'hF);
        expect_out("R7", 3, 1);
        cyc(2);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule